// File: doc/BRIEF.md
# Digital PLL Operating-Mode Sequencer with Holdover Memory

This block decides, every clock, whether a digital PLL runs free, tracks its reference, or coasts on a remembered frequency. It sits between the loop filter and the numerically controlled oscillator. While the loop is locked it passes the loop filter's frequency word to the oscillator and builds a smoothed copy of that word. When the reference goes away it switches the oscillator over to that smoothed copy. If there is no trustworthy copy yet, it falls back to a zero offset, so the oscillator runs on the system clock alone.

Configuration selects the smoothing strength, the number of locked samples needed before the history is trusted, and an override that pins the mode. Three lock-loss causes reported by the loop are kept as sticky flags until software clears them by writing a one.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: During and right after reset, mode_o is free-run (0), freq_o is 0, hist_valid_o is 0 and loss_sticky_o is 0.
- R2: While mode_o is free-run (encoding 0), freq_o is 0.
- R3: With force_mode_i = 0, the mode moves from free-run or holdover to locked (encoding 1) on the clock edge where ref_valid_i and lock_i are both high.
- R4: While mode_o is locked, freq_o equals lf_freq_i in the same cycle.
- R5: On each edge with mode_o locked, the history takes the value lf_freq_i if it holds no samples yet. Otherwise it becomes h + ((lf_freq_i - h) >>> avg_shift_i), computed in signed arithmetic. The sample count goes up by one and stops at its maximum.
- R6: hist_valid_o is high when the sample count is nonzero and at least valid_cnt_i. On each edge with mode_o free-run, the count and the history are cleared.
- R7: With force_mode_i = 0, locked mode is left on the edge where ref_valid_i or lock_i is low. It moves to holdover (encoding 2) if hist_valid_o is high before that edge, and to free-run otherwise.
- R8: While mode_o is holdover, freq_o equals the history, and the history does not change.
- R9: loss_sticky_o bit 0 (fast loss), bit 1 (fine phase loss) and bit 2 (hard frequency limit) are each set on the edge after the matching loss_evt_i bit is high. Each is cleared by a one on the matching loss_clr_i bit. When a set and a clear arrive together, the set wins.
- R10: force_mode_i = 1, 2 or 3 makes the mode free-run, locked or holdover on the next edge, regardless of the reference inputs. A value of 0 leaves the automatic rules in control, starting from the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lf_freq_i | input | FW_W | Loop filter frequency word, signed |
| ref_valid_i | input | 1 | Selected reference is usable |
| lock_i | input | 1 | Loop reports lock |
| avg_shift_i | input | SH_W | History smoothing shift |
| valid_cnt_i | input | CNT_W | Locked samples required for a valid history |
| force_mode_i | input | 2 | 0 automatic, 1 free-run, 2 locked, 3 holdover |
| loss_evt_i | input | 3 | Lock-loss events: fast, fine phase, hard limit |
| loss_clr_i | input | 3 | Write-one clear for the sticky loss flags |
| mode_o | output | 2 | Current mode: 0 free-run, 1 locked, 2 holdover |
| freq_o | output | FW_W | Frequency word applied to the oscillator |
| hist_valid_o | output | 1 | Holdover history is trusted |
| loss_sticky_o | output | 3 | Sticky lock-loss flags |

## Verification
Two pairs of functions can land in the same cycle. First, the reference can drop on the very edge that would bring the sample count up to the threshold. The mode decision must use the count from before that edge, while the history still takes that final sample. Second, a loss event and the write-one clear can hit the same flag together. The bench forces both collisions with directed sequences, and the random phases also produce them often through short lock bursts and dense event and clear traffic. A cycle-accurate reference model checks every cycle, so each collision is judged on the exact edge where it happens.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_LOCK = 2'd1,
    MODE_HOLD = 2'd2
  } dpll_mode_e;

  typedef enum logic [1:0] {
    FRC_AUTO = 2'd0,
    FRC_FREE = 2'd1,
    FRC_LOCK = 2'd2,
    FRC_HOLD = 2'd3
  } dpll_force_e;

  localparam int unsigned LOSS_N = 3;
endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_valid_i,
  input  logic       lock_i,
  input  logic       hist_valid_i,
  input  logic [1:0] force_mode_i,
  output dpll_mode_e mode_o
);
  dpll_mode_e mode_q, mode_d;
  logic       ref_ok;

  assign ref_ok = ref_valid_i & lock_i;

  always_comb begin
    mode_d = mode_q;
    unique case (dpll_force_e'(force_mode_i))
      FRC_FREE: mode_d = MODE_FREE;
      FRC_LOCK: mode_d = MODE_LOCK;
      FRC_HOLD: mode_d = MODE_HOLD;
      default: begin
        unique case (mode_q)
          MODE_FREE, MODE_HOLD: if (ref_ok) mode_d = MODE_LOCK;
          MODE_LOCK: if (!ref_ok) mode_d = hist_valid_i ? MODE_HOLD : MODE_FREE;
          default: mode_d = MODE_FREE;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_FREE;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/dpll_hold_avg.sv
module dpll_hold_avg
  import dpll_mode_pkg::*;
#(
  parameter int unsigned FW_W  = 24,
  parameter int unsigned SH_W  = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  dpll_mode_e              mode_i,
  input  logic signed [FW_W-1:0]  lf_freq_i,
  input  logic [SH_W-1:0]         avg_shift_i,
  input  logic [CNT_W-1:0]        valid_cnt_i,
  output logic signed [FW_W-1:0]  hist_o,
  output logic                    hist_valid_o
);
  localparam int unsigned DW = FW_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic signed [FW_W-1:0] hist_q;
  logic [CNT_W-1:0]       cnt_q;
  logic signed [DW-1:0]   diff, step;
  logic signed [DW-1:0]   sum;

  // Step toward the loop word; result stays between old history and input, so no overflow.
  assign diff = DW'(lf_freq_i) - DW'(hist_q);
  assign step = diff >>> avg_shift_i;
  assign sum  = DW'(hist_q) + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (mode_i == MODE_FREE) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (mode_i == MODE_LOCK) begin
      hist_q <= (cnt_q == '0) ? lf_freq_i : sum[FW_W-1:0];
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hist_o       = hist_q;
  assign hist_valid_o = (cnt_q != '0) && (cnt_q >= valid_cnt_i);
endmodule

// File: rtl/dpll_loss_sticky.sv
module dpll_loss_sticky #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (evt_i[k]) flag_q <= 1'b1;
      else if (clr_i[k]) flag_q <= 1'b0;
    end
    assign flag_o[k] = flag_q;
  end
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int unsigned FW_W  = 24,
  parameter int unsigned SH_W  = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic signed [FW_W-1:0] lf_freq_i,
  input  logic                   ref_valid_i,
  input  logic                   lock_i,
  input  logic [SH_W-1:0]        avg_shift_i,
  input  logic [CNT_W-1:0]       valid_cnt_i,
  input  logic [1:0]             force_mode_i,
  input  logic [LOSS_N-1:0]      loss_evt_i,
  input  logic [LOSS_N-1:0]      loss_clr_i,
  output logic [1:0]             mode_o,
  output logic signed [FW_W-1:0] freq_o,
  output logic                   hist_valid_o,
  output logic [LOSS_N-1:0]      loss_sticky_o
);
  dpll_mode_e             mode;
  logic signed [FW_W-1:0] hist;
  logic                   hist_valid;

  dpll_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ref_valid_i  (ref_valid_i),
    .lock_i       (lock_i),
    .hist_valid_i (hist_valid),
    .force_mode_i (force_mode_i),
    .mode_o       (mode)
  );

  dpll_hold_avg #(.FW_W(FW_W), .SH_W(SH_W), .CNT_W(CNT_W)) u_avg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode),
    .lf_freq_i    (lf_freq_i),
    .avg_shift_i  (avg_shift_i),
    .valid_cnt_i  (valid_cnt_i),
    .hist_o       (hist),
    .hist_valid_o (hist_valid)
  );

  dpll_loss_sticky #(.N(LOSS_N)) u_loss (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (loss_evt_i),
    .clr_i  (loss_clr_i),
    .flag_o (loss_sticky_o)
  );

  always_comb begin
    unique case (mode)
      MODE_LOCK: freq_o = lf_freq_i;
      MODE_HOLD: freq_o = hist;
      default:   freq_o = '0;
    endcase
  end

  assign mode_o       = mode;
  assign hist_valid_o = hist_valid;
endmodule

// File: rtl/dpll_mode_ctrl_chk.sv
module dpll_mode_ctrl_chk #(
  parameter int unsigned FW_W  = 24,
  parameter int unsigned SH_W  = 4,
  parameter int unsigned CNT_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic signed [FW_W-1:0] lf_freq_i,
  input logic                   ref_valid_i,
  input logic                   lock_i,
  input logic [1:0]             force_mode_i,
  input logic [2:0]             loss_evt_i,
  input logic [1:0]             mode_o,
  input logic signed [FW_W-1:0] freq_o,
  input logic                   hist_valid_o,
  input logic [2:0]             loss_sticky_o
);
  // R2
  free_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd0 |-> freq_o == '0);

  // R8
  hold_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && $past(mode_o) == 2'd2) |-> $stable(freq_o));

  // R7
  lock_to_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && force_mode_i == 2'd0 && !ref_valid_i && !hist_valid_o) |=> mode_o == 2'd0);

  // R7
  lock_to_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && force_mode_i == 2'd0 && !lock_i && hist_valid_o) |=> mode_o == 2'd2);

  // R3
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_mode_i == 2'd0 && ref_valid_i && lock_i) |=> mode_o == 2'd1);

  // R9
  sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loss_evt_i != 3'b000) |=> ((loss_sticky_o & $past(loss_evt_i)) == $past(loss_evt_i)));

  // R10
  force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_mode_i != 2'd0) |=> mode_o == $past(force_mode_i) - 2'd1);

  // R4
  lock_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && $stable(lf_freq_i)) |-> $stable(freq_o) || $past(mode_o) != 2'd1);
endmodule

bind dpll_mode_ctrl dpll_mode_ctrl_chk #(.FW_W(FW_W), .SH_W(SH_W), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lf_freq_i     (lf_freq_i),
  .ref_valid_i   (ref_valid_i),
  .lock_i        (lock_i),
  .force_mode_i  (force_mode_i),
  .loss_evt_i    (loss_evt_i),
  .mode_o        (mode_o),
  .freq_o        (freq_o),
  .hist_valid_o  (hist_valid_o),
  .loss_sticky_o (loss_sticky_o)
);

// File: tb/tb_dpll_mode_ctrl.sv
module tb_dpll_mode_ctrl;
  localparam int FW_W = 24, SH_W = 4, CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic signed [FW_W-1:0] lf = '0;
  logic ref_v = 1'b0, lock = 1'b0;
  logic [SH_W-1:0] shift = 4'd2;
  logic [CNT_W-1:0] vcnt = 8'd4;
  logic [1:0] frc = 2'd0;
  logic [2:0] evt = '0, clr = '0;
  logic [1:0] mode;
  logic signed [FW_W-1:0] freq;
  logic hv;
  logic [2:0] sticky;

  int tests = 0, fails = 0;

  // reference model state
  logic [1:0] m_mode;
  logic signed [FW_W-1:0] m_hist;
  logic [CNT_W-1:0] m_cnt;
  logic [2:0] m_stk;

  always #10 clk = ~clk;

  dpll_mode_ctrl #(.FW_W(FW_W), .SH_W(SH_W), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lf_freq_i(lf), .ref_valid_i(ref_v), .lock_i(lock),
    .avg_shift_i(shift), .valid_cnt_i(vcnt), .force_mode_i(frc), .loss_evt_i(evt),
    .loss_clr_i(clr), .mode_o(mode), .freq_o(freq), .hist_valid_o(hv), .loss_sticky_o(sticky)
  );

  function automatic logic m_hv(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] v);
    return (c != 0) && (c >= v);
  endfunction

  function automatic logic signed [FW_W-1:0] m_step(input logic signed [FW_W-1:0] h,
      input logic signed [FW_W-1:0] x, input logic [SH_W-1:0] s);
    logic signed [FW_W:0] d;
    d = (FW_W+1)'(x) - (FW_W+1)'(h);
    d = d >>> s;
    return h + d[FW_W-1:0];
  endfunction

  function automatic logic signed [FW_W-1:0] m_freq();
    case (m_mode)
      2'd1: return lf;
      2'd2: return m_hist;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2'd0; m_hist = '0; m_cnt = '0; m_stk = '0;
    end else begin
      logic [1:0] nm;
      logic ok;
      ok = ref_v && lock;
      nm = m_mode;
      if (frc != 0) nm = frc - 2'd1;
      else if (m_mode == 2'd1) begin
        if (!ok) nm = m_hv(m_cnt, vcnt) ? 2'd2 : 2'd0;
      end else if (ok) nm = 2'd1;
      if (m_mode == 2'd0) begin
        m_hist = '0; m_cnt = '0;
      end else if (m_mode == 2'd1) begin
        m_hist = (m_cnt == 0) ? lf : m_step(m_hist, lf, shift);
        if (m_cnt != {CNT_W{1'b1}}) m_cnt = m_cnt + 1'b1;
      end
      m_stk = (m_stk & ~clr) | evt;
      m_mode = nm;
    end
  end

  task automatic chk(input string req, input logic [FW_W-1:0] act, input logic [FW_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R3 R7 R10 mode", FW_W'(mode), FW_W'(m_mode));
    if (m_mode == 2'd0) chk("R2 freq", freq, '0);
    else if (m_mode == 2'd1) chk("R4 freq", freq, lf);
    else chk("R5 R8 freq", freq, m_freq());
    chk("R6 hist_valid", FW_W'(hv), FW_W'(m_hv(m_cnt, vcnt)));
    chk("R9 sticky", FW_W'(sticky), FW_W'(m_stk));
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
  endtask

  initial begin
    logic signed [FW_W-1:0] base;
    logic signed [FW_W-1:0] held;
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 mode", FW_W'(mode), '0);
    chk("R1 freq", freq, '0);
    chk("R1 hist_valid", FW_W'(hv), '0);
    chk("R1 sticky", FW_W'(sticky), '0);
    rst_n = 1'b1;
    cyc();
    chk("R1 mode after release", FW_W'(mode), '0);

    // R7: reference lost before history valid -> free-run
    lf = 24'sd1000; ref_v = 1; lock = 1;
    cyc(); cyc();
    ref_v = 0;
    cyc();
    chk("R7 early loss to free", FW_W'(mode), 24'd0);
    cyc();

    // R7 collision: drop on the edge that brings count to threshold -> still free
    ref_v = 1;
    cyc(); // now locked, count 0
    lf = 24'sd2000; cyc(); lf = 24'sd2100; cyc(); lf = 24'sd2200; cyc(); // count 3
    ref_v = 0; lf = 24'sd2300;
    cyc();
    chk("R7 drop at threshold edge", FW_W'(mode), 24'd0);

    // R5 R8: full history then holdover
    ref_v = 1; lf = -24'sd500;
    cyc();
    for (int i = 0; i < 10; i++) begin lf = -24'sd500 + 24'(i * 37); cyc(); end
    lock = 0;
    cyc();
    chk("R7 to holdover", FW_W'(mode), 24'd2);
    held = freq;
    lf = 24'sd77777;
    cyc(); cyc();
    chk("R8 holdover frozen", freq, held);
    lock = 1;
    cyc();
    chk("R3 relock from holdover", FW_W'(mode), 24'd1);

    // R9: set and clear collide on bit 1, set wins; then clear alone
    evt = 3'b010; clr = 3'b010;
    cyc();
    evt = 3'b000; clr = 3'b000;
    chk("R9 set beats clear", FW_W'(sticky[1]), 24'd1);
    clr = 3'b010;
    cyc();
    clr = 3'b000;
    chk("R9 clear by one", FW_W'(sticky[1]), 24'd0);

    // R10: forced holdover with reference good
    frc = 2'd3;
    cyc();
    chk("R10 forced hold", FW_W'(mode), 24'd2);
    frc = 2'd1;
    cyc();
    chk("R10 forced free", FW_W'(mode), 24'd0);
    frc = 2'd0;
    cyc();

    // constrained random
    base = 24'sd3000;
    for (int n = 0; n < 20000; n++) begin
      if ($urandom_range(15) == 0) ref_v = ~ref_v;
      lock = ref_v && ($urandom_range(20) != 0);
      if ($urandom_range(200) == 0) base = 24'($signed($urandom_range(200000)) - 100000);
      lf = base + 24'($signed($urandom_range(400)) - 200);
      if ($urandom_range(300) == 0) shift = 4'($urandom_range(8));
      if ($urandom_range(300) == 0) vcnt = 8'($urandom_range(12));
      if ($urandom_range(40) == 0) frc = 2'($urandom_range(3));
      else if ($urandom_range(3) == 0) frc = 2'd0;
      evt = ($urandom_range(7) == 0) ? 3'($urandom_range(7)) : 3'b000;
      clr = ($urandom_range(5) == 0) ? 3'($urandom_range(7)) : 3'b000;
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule